// File: doc/BRIEF.md
# Key Slot Permission Flag Controller

This block keeps a small table of key slots. Each slot holds a 256-bit key and a 32-bit flag word that says whether the slot exists, whether it is enabled, and what it may be used for. Software writes a new key into eight write-only staging words. It then writes a slot number to a commit register, and the key is copied into that slot only when the slot's flags allow it. Two more command registers let software remove selected permission bits from a slot, or fetch a slot's flag word into a read-only response register. Cipher engines read keys through a separate slot-select port.

Permissions can only shrink. A clear command removes only the bits that are marked clearable. No command can turn a flag back on. The one way to restore the flags is the coprocessor reset input, which reloads every slot's flags from the start-up table. Every command passes through a small state machine that runs for three states:

- ST_IDLE to ST_LOOKUP when a command write is accepted.
- ST_LOOKUP to ST_APPLY unconditionally, after the slot's flags are registered.
- ST_APPLY to ST_IDLE unconditionally, after the commit, clear or response update is done.
- Any state to ST_IDLE on the coprocessor reset.

Top module: `keyslot_ctrl`

## Requirements
- R1: Staging words (byte offsets 0x00–0x1C, word w at 4*w, word 0 = key bits 31:0) and the command registers at 0x20, 0x24 and 0x28 always read as zero. Address bits 1:0 are ignored.
- R2: Writing a slot number in bits 15:0 to 0x20 copies the staged key into that slot when its flag bit 1 (enabled) and bit 27 (direct write allowed) are both 1. The new key is visible on `key_out` once the command completes.
- R3: A commit that is refused leaves the slot's key unchanged and sets a sticky error flag, read as bit 0 at offset 0x34 (status). The error flag stays set until a reset.
- R4: A write to 0x24 carries the slot number in bits 15:0 and a mask in bits 31:16. Mask bit n clears flag bit 16+n, but only for the clearable bits 16–20 and 26–28.
- R5: Flag bits 0–2 and 21–25 never change. No command ever sets a flag bit that is 0.
- R6: Writing a slot number in bits 15:0 to 0x28 loads that slot's flag word into the response register, read at offset 0x2C.
- R7: A slot number of NSLOTS or more, or a slot whose flag bit 0 (exists) is 0, is absent. A query of an absent slot returns 0. A clear of an absent slot changes nothing. A commit to an absent slot is refused as in R3.
- R8: A one-cycle `cop_rst` does three things: it reloads all flags from the start-up table, it clears the error flag and the response register, and it returns the controller to idle. Stored keys are kept.
- R9: An accepted command raises `busy` for exactly two cycles. Its result is visible after the second of those cycles. Command writes that arrive while `busy` is high are dropped, and staging writes are always taken.
- R10: After `rst_n`, keys and the response are zero, the error flag is 0 and `busy` is 0. The start-up flags of slot i (for i < LIVE_SLOTS, default 14) are set as follows:
  - bit 0 = 1.
  - bit 1 = 1 except for slot 3.
  - bit 2 = i odd.
  - bits 20:16 = 0x1F.
  - bits 25:21 = i.
  - bits 26 and 28 = 1.
  - bit 27 = 1 except for slot 5.
  - All other bits are 0.
  
  Slots at or above LIVE_SLOTS have all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_rst | input | 1 | Synchronous coprocessor reset, restores flags |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| busy | output | 1 | Command in progress |
| key_sel | input | $clog2(NSLOTS) | Slot whose key drives `key_out` |
| key_out | output | 256 | Key held in the selected slot |

## Verification
A command write is sampled at edge E0. The slot's flags are registered at E1. The key, flag and response updates and the error flag land at E2. The bench therefore issues each command at a falling edge and waits two more falling edges before it reads `bus_rdata` or `key_out`. The busy test samples `busy` at the falling edge after each of E0, E1 and E2. It also places a second command at the falling edge after E0, where it lands on E1 and must be dropped. Register reads are combinational, so the bench samples them at the same falling edge at which it sets the address.

// File: rtl/ksc_pkg.sv
package ksc_pkg;
    localparam int KEY_W   = 256;
    localparam int WORD_W  = 32;
    localparam int NWORDS  = KEY_W / WORD_W;

    localparam logic [31:0] CLEARABLE_MASK = 32'h1C1F_0000;
    localparam logic [31:0] FIXED_MASK     = 32'h03E0_0007;

    localparam logic [7:0] OFS_COMMIT = 8'h20;
    localparam logic [7:0] OFS_CLEAR  = 8'h24;
    localparam logic [7:0] OFS_QUERY  = 8'h28;
    localparam logic [7:0] OFS_RESP   = 8'h2C;
    localparam logic [7:0] OFS_STATUS = 8'h34;

    typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_APPLY} ksc_state_e;
    typedef enum logic [1:0] {OP_NONE, OP_COMMIT, OP_CLEAR, OP_QUERY} ksc_op_e;

    // Start-up flag word of one slot
    function automatic logic [31:0] slot_init_flags(input int idx, input int live);
        logic [31:0] f;
        f = '0;
        if (idx < live) begin
            f[0]     = 1'b1;
            f[1]     = (idx != 3);
            f[2]     = (idx % 2) != 0;
            f[20:16] = 5'h1F;
            f[25:21] = 5'(idx);
            f[26]    = 1'b1;
            f[27]    = (idx != 5);
            f[28]    = 1'b1;
        end
        return f;
    endfunction
endpackage

// File: rtl/ksc_stage.sv
module ksc_stage
    import ksc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [KEY_W-1:0] stage_key
);
    logic [7:0] word_addr;
    assign word_addr = bus_addr & 8'hFC;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stage_key[w*WORD_W +: WORD_W] <= '0;
            else if (bus_wr && word_addr == 8'(w * 4))
                stage_key[w*WORD_W +: WORD_W] <= bus_wdata;
        end
    end
endmodule

// File: rtl/ksc_flag_table.sv
module ksc_flag_table
    import ksc_pkg::*;
#(
    parameter int NSLOTS     = 16,
    parameter int LIVE_SLOTS = 14,
    localparam int IDX_W     = $clog2(NSLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cop_rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [31:0]          wr_data,
    output logic [NSLOTS*32-1:0] flags_flat
);
    logic [31:0] flags_q [NSLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOTS; i++) flags_q[i] <= slot_init_flags(i, LIVE_SLOTS);
        end else if (cop_rst) begin
            for (int i = 0; i < NSLOTS; i++) flags_q[i] <= slot_init_flags(i, LIVE_SLOTS);
        end else if (we) begin
            flags_q[wr_idx] <= wr_data;
        end
    end

    for (genvar s = 0; s < NSLOTS; s++) begin : g_flat
        assign flags_flat[s*32 +: 32] = flags_q[s];
    end
endmodule

// File: rtl/ksc_key_store.sv
module ksc_key_store
    import ksc_pkg::*;
#(
    parameter int NSLOTS = 16,
    localparam int IDX_W = $clog2(NSLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key
);
    logic [KEY_W-1:0] keys_q [NSLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOTS; i++) keys_q[i] <= '0;
        end else if (we) begin
            keys_q[wr_idx] <= wr_key;
        end
    end

    assign rd_key = keys_q[rd_idx];
endmodule

// File: rtl/ksc_ctrl.sv
module ksc_ctrl
    import ksc_pkg::*;
#(
    parameter int NSLOTS = 16,
    localparam int IDX_W = $clog2(NSLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cop_rst,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    input  logic [31:0]      look_flags,
    output logic [IDX_W-1:0] slot_idx,
    output logic             busy,
    output logic             commit_en,
    output logic             err_set,
    output logic             flag_we,
    output logic [31:0]      flag_wdata,
    output logic             resp_we,
    output logic [31:0]      resp_wdata
);
    ksc_state_e state_q, state_d;
    ksc_op_e    op_q, op_new;
    logic [15:0] id_q, mask_q;
    logic [31:0] look_q;
    logic        hit_q;
    logic        accept;
    logic        commit_ok;
    logic [7:0]  word_addr;

    assign word_addr = bus_addr & 8'hFC;

    always_comb begin
        if (word_addr == OFS_COMMIT)     op_new = OP_COMMIT;
        else if (word_addr == OFS_CLEAR) op_new = OP_CLEAR;
        else if (word_addr == OFS_QUERY) op_new = OP_QUERY;
        else                             op_new = OP_NONE;
    end

    assign accept = bus_wr && (state_q == ST_IDLE) && (op_new != OP_NONE) && !cop_rst;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= ST_IDLE;
        else if (cop_rst) state_q <= ST_IDLE;
        else              state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // command capture and flag lookup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            id_q   <= '0;
            mask_q <= '0;
            look_q <= '0;
            hit_q  <= 1'b0;
        end else if (accept) begin
            op_q   <= op_new;
            id_q   <= bus_wdata[15:0];
            mask_q <= bus_wdata[31:16];
        end else if (state_q == ST_LOOKUP) begin
            look_q <= look_flags;
            hit_q  <= (32'(id_q) < NSLOTS) && look_flags[0];
        end
    end

    assign slot_idx  = id_q[IDX_W-1:0];
    assign busy      = (state_q != ST_IDLE);
    assign commit_ok = hit_q && look_q[1] && look_q[27];

    // outputs
    always_comb begin
        commit_en  = 1'b0;
        err_set    = 1'b0;
        flag_we    = 1'b0;
        flag_wdata = look_q;
        resp_we    = 1'b0;
        resp_wdata = '0;
        unique case (state_q)
            ST_APPLY: begin
                unique case (op_q)
                    OP_COMMIT: begin
                        if (commit_ok) commit_en = 1'b1;
                        else           err_set   = 1'b1;
                    end
                    OP_CLEAR: begin
                        if (hit_q) begin
                            flag_we    = 1'b1;
                            flag_wdata = look_q & ~({mask_q, 16'h0000} & CLEARABLE_MASK);
                        end
                    end
                    OP_QUERY: begin
                        resp_we    = 1'b1;
                        resp_wdata = hit_q ? look_q : 32'h0;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/keyslot_ctrl.sv
module keyslot_ctrl
    import ksc_pkg::*;
#(
    parameter int NSLOTS     = 16,
    parameter int LIVE_SLOTS = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cop_rst,
    input  logic                      bus_wr,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      busy,
    input  logic [$clog2(NSLOTS)-1:0] key_sel,
    output logic [KEY_W-1:0]          key_out
);
    localparam int IDX_W = $clog2(NSLOTS);

    logic [KEY_W-1:0]     stage_key;
    logic [NSLOTS*32-1:0] flags_flat;
    logic [IDX_W-1:0]     slot_idx;
    logic [31:0]          look_flags;
    logic                 commit_en, err_set, flag_we, resp_we;
    logic [31:0]          flag_wdata, resp_wdata;
    logic [31:0]          resp_q;
    logic                 err_q;
    logic [7:0]           word_addr;

    ksc_stage u_stage (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stage_key(stage_key)
    );

    ksc_flag_table #(.NSLOTS(NSLOTS), .LIVE_SLOTS(LIVE_SLOTS)) u_flags (
        .clk(clk), .rst_n(rst_n), .cop_rst(cop_rst), .we(flag_we),
        .wr_idx(slot_idx), .wr_data(flag_wdata), .flags_flat(flags_flat)
    );

    ksc_key_store #(.NSLOTS(NSLOTS)) u_keys (
        .clk(clk), .rst_n(rst_n), .we(commit_en), .wr_idx(slot_idx),
        .wr_key(stage_key), .rd_idx(key_sel), .rd_key(key_out)
    );

    assign look_flags = flags_flat[slot_idx*32 +: 32];

    ksc_ctrl #(.NSLOTS(NSLOTS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cop_rst(cop_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .look_flags(look_flags),
        .slot_idx(slot_idx), .busy(busy), .commit_en(commit_en),
        .err_set(err_set), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .resp_we(resp_we), .resp_wdata(resp_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
            err_q  <= 1'b0;
        end else if (cop_rst) begin
            resp_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (resp_we) resp_q <= resp_wdata;
            if (err_set) err_q  <= 1'b1;
        end
    end

    assign word_addr = bus_addr & 8'hFC;

    always_comb begin
        unique case (word_addr)
            OFS_RESP:   bus_rdata = resp_q;
            OFS_STATUS: bus_rdata = {31'b0, err_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ksc_checker.sv
module ksc_checker
    import ksc_pkg::*;
#(
    parameter int NSLOTS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cop_rst,
    input logic                 bus_wr,
    input logic [7:0]           bus_addr,
    input logic [31:0]          bus_rdata,
    input logic                 busy,
    input logic                 err,
    input logic [NSLOTS*32-1:0] flags_flat
);
    logic [7:0] waddr;
    logic       trig_wr;
    logic [NSLOTS*32-1:0] fixed_vec;

    assign waddr   = bus_addr & 8'hFC;
    assign trig_wr = bus_wr && (waddr == OFS_COMMIT || waddr == OFS_CLEAR || waddr == OFS_QUERY);

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        assign fixed_vec[s*32 +: 32] = flags_flat[s*32 +: 32] & FIXED_MASK;

        assert_no_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cop_rst) |-> ((flags_flat[s*32 +: 32] & ~$past(flags_flat[s*32 +: 32])) == 32'h0));
    end

    assert_readzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (waddr < OFS_RESP) |-> (bus_rdata == 32'h0));

    assert_fixed_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(fixed_vec));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cop_rst) |=> err);

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n || cop_rst)
        (!busy && trig_wr) |=> busy);

    assert_busy_second_R9: assert property (@(posedge clk) disable iff (!rst_n || cop_rst)
        $rose(busy) |=> busy);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n || cop_rst)
        (busy && $past(busy)) |=> !busy);

    assert_cop_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cop_rst |=> (!err && !busy));
endmodule

bind keyslot_ctrl ksc_checker #(.NSLOTS(NSLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cop_rst(cop_rst), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .busy(busy),
    .err(err_q), .flags_flat(flags_flat)
);

// File: tb/sim_keyslot_ctrl.sv
module sim_keyslot_ctrl;
    localparam int NS = 16;
    localparam int LIVE = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cop_rst = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         busy;
    logic [3:0]   key_sel = '0;
    logic [255:0] key_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0]  exp_flags [NS];
    logic [255:0] staged;

    always #2 clk = ~clk;

    keyslot_ctrl #(.NSLOTS(NS), .LIVE_SLOTS(LIVE)) u0 (
        .clk(clk), .rst_n(rst_n), .cop_rst(cop_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .key_sel(key_sel), .key_out(key_out)
    );

    function automatic logic [31:0] model_init(input int i);
        logic [31:0] f = 32'h0;
        if (i < LIVE) begin
            f = 32'h141F_0001 | (32'(i) << 21);
            if (i != 3) f |= 32'h2;
            if (i % 2 == 1) f |= 32'h4;
            if (i != 5) f |= 32'h0800_0000;
        end
        return f;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NS; i++) exp_flags[i] = model_init(i);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic chk_key(input string req, input logic [3:0] slot, input logic [255:0] expv);
        key_sel = slot;
        #1;
        checks++;
        if (key_out !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, key_out, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_cmd(input logic [7:0] a, input logic [31:0] d);
        bus_write(a, d);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic query_check(input string req, input logic [15:0] id, input logic [31:0] expv);
        logic [31:0] r;
        do_cmd(8'h28, {16'h0, id});
        read_reg(8'h2C, r);
        chk(req, r, expv);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        read_reg(8'h2C, r); chk("R10 response zero", r, 32'h0);
        read_reg(8'h34, r); chk("R10 error clear", r, 32'h0);
        chk("R10 idle", 32'(busy), 32'h0);
        chk_key("R10 key zero", 4'd0, 256'h0);
        query_check("R10 init flags slot0", 16'd0, model_init(0));
    endtask

    task automatic t_readzero();
        logic [31:0] r;
        for (int w = 0; w < 8; w++) begin
            staged[w*32 +: 32] = 32'hA500_0000 + 32'(w * 32'h111) + 32'h7;
            bus_write(8'(w * 4), staged[w*32 +: 32]);
        end
        for (int w = 0; w < 11; w++) begin
            read_reg(8'(w * 4), r);
            chk("R1 write-only reads zero", r, 32'h0);
        end
        read_reg(8'h1E, r); chk("R1 byte bits ignored", r, 32'h0);
    endtask

    task automatic t_commit();
        logic [31:0] r;
        do_cmd(8'h20, 32'd2);
        chk_key("R2 commit slot2", 4'd2, staged);
        read_reg(8'h34, r); chk("R2 no error", r, 32'h0);
        do_cmd(8'h20, 32'd3);
        chk_key("R3 disabled slot unchanged", 4'd3, 256'h0);
        read_reg(8'h34, r); chk("R3 error set", r, 32'h1);
        do_cmd(8'h20, 32'd5);
        chk_key("R3 no-direct-write slot unchanged", 4'd5, 256'h0);
        read_reg(8'h34, r); chk("R3 error sticky", r, 32'h1);
    endtask

    task automatic t_query_all();
        for (int i = 0; i < NS; i++) query_check("R6 query flags", 16'(i), exp_flags[i]);
    endtask

    task automatic t_clear();
        do_cmd(8'h24, 32'hFFFF_0002);
        exp_flags[2] &= ~32'h1C1F_0000;
        query_check("R4 clear all clearable slot2", 16'd2, exp_flags[2]);
        do_cmd(8'h24, 32'h03E0_0006);
        query_check("R5 fixed bits not cleared", 16'd6, exp_flags[6]);
        do_cmd(8'h24, 32'h0800_0007);
        exp_flags[7] &= ~32'h0800_0000;
        query_check("R4 clear direct-write slot7", 16'd7, exp_flags[7]);
        do_cmd(8'h20, 32'd7);
        chk_key("R4 commit refused after clear", 4'd7, 256'h0);
        do_cmd(8'h24, 32'h0000_0002);
        query_check("R5 cleared bits stay clear", 16'd2, exp_flags[2]);
    endtask

    task automatic t_absent();
        query_check("R7 query absent slot14", 16'd14, 32'h0);
        query_check("R7 query out-of-range id", 16'h0104, 32'h0);
        do_cmd(8'h24, 32'hFFFF_0014);
        query_check("R7 clear out-of-range no effect", 16'd4, exp_flags[4]);
        do_cmd(8'h20, 32'h0000_0100);
        chk_key("R7 commit out-of-range refused", 4'd0, 256'h0);
    endtask

    task automatic t_busy();
        logic [31:0] r;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'd0;
        @(negedge clk);
        chk("R9 busy after accept", 32'(busy), 32'h1);
        bus_wdata = 32'd1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9 busy second cycle", 32'(busy), 32'h1);
        @(negedge clk);
        chk("R9 busy ends", 32'(busy), 32'h0);
        read_reg(8'h2C, r);
        chk("R9 write during busy dropped", r, exp_flags[0]);
    endtask

    task automatic t_cop();
        logic [31:0] r;
        @(negedge clk); cop_rst = 1'b1;
        @(negedge clk); cop_rst = 1'b0;
        model_reset();
        read_reg(8'h34, r); chk("R8 error cleared", r, 32'h0);
        read_reg(8'h2C, r); chk("R8 response cleared", r, 32'h0);
        query_check("R8 slot2 flags restored", 16'd2, model_init(2));
        query_check("R8 slot7 flags restored", 16'd7, model_init(7));
        chk_key("R8 keys kept", 4'd2, staged);
        do_cmd(8'h20, 32'd7);
        read_reg(8'h34, r); chk("R8 restored permission usable", r, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        staged = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readzero();
        t_commit();
        t_query_all();
        t_clear();
        t_absent();
        t_busy();
        t_cop();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule